// File: doc/BRIEF.md
# Class-Pair RAW Interlock

This block sits beside the decode stage of an in-order, single-issue pipeline and decides whether the instruction in decode has to wait. The wait is needed when one of its source registers is written by an older instruction that is still in flight. It keeps a short table of recently issued producers, indexed by age. Each row holds the producer's instruction class and its destination register, with that register's file (integer or floating point).

The number of cycles a consumer must trail its producer is not one fixed latency. It depends on the pair of producer class and consumer class. An FP ALU result needs three cycles between producer and consumer before another FP ALU op may read it, and two before a store-double may take it as data. A load-double result needs one cycle before an FP ALU op, and none before a store-double. Integer results need none before integer ops.

The block raises `stall` and reports the number of bubbles still owed. While stalled, decode keeps its instruction, an empty slot enters the pipe and fetch stays frozen. A two-state controller records whether decode is holding a stalled instruction:
- FLOW: decode is passing instructions.
- HOLD: decode is holding an instruction that stalled in the previous cycle.

The controller moves between the states on three transitions:
- T_DETECT: from FLOW to HOLD when a hazard appears.
- T_KEEP: from HOLD to HOLD while bubbles are still owed.
- T_RELEASE: from HOLD to FLOW when the count reaches zero.

Top module: `raw_gap_interlock`

## Requirements
- R1: An FP ALU producer (class code 1) read by an FP ALU consumer (class code 1) stalls that consumer until 3 cycles, counting stall cycles and empty slots, lie between their issues. With k such cycles already elapsed, `bubbles` = 3 - k.
- R2: An FP ALU producer read as store data by a store-double consumer (class code 3, source B) needs 2 intervening cycles, so `bubbles` = 2 - k.
- R3: A load-double producer (class code 2) read by an FP ALU consumer needs 1 intervening cycle, so `bubbles` = 1 - k.
- R4: A load-double producer read as store data by a store-double consumer never causes a stall.
- R5: An integer producer (class code 0) read by an integer consumer never causes a stall.
- R6: Register files are separate. FP ALU and load-double write the FP file, and integer ops write the integer file. Source A is in the FP file only for class 1. Source B is in the FP file for classes 1 and 3. Any other source is in the integer file. A match needs equal register number and equal file.
- R7: `issue` = `dec_valid` and not `stall`. When `dec_valid` is high, `stall` is high exactly when `bubbles` is non-zero. While the same instruction is held, `bubbles` falls by one each cycle and the instruction issues in the cycle it reaches zero.
- R8: When several tracked producers match the sources of one consumer, `bubbles` is the largest of their remaining requirements.
- R9: A producer no longer affects any consumer once its largest requirement has elapsed. With k at or above the pair's gap, the result is 0 bubbles.
- R10: A disabled source never matches. A producer issued with `dec_dst_en` low is not tracked. With `dec_valid` low, `stall` and `issue` are both low.
- R11: After reset the table is empty, so no consumer stalls and `bubbles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_cls | input | 2 | Class: 0 integer, 1 FP ALU, 2 load-double, 3 store-double |
| dec_dst_en | input | 1 | Instruction writes a destination |
| dec_dst | input | REG_W | Destination register number |
| dec_sa_en | input | 1 | Source A in use |
| dec_sa | input | REG_W | Source A register number |
| dec_sb_en | input | 1 | Source B in use |
| dec_sb | input | REG_W | Source B register number |
| stall | output | 1 | Hold decode, freeze fetch, insert an empty slot |
| issue | output | 1 | Decode instruction leaves this cycle |
| bubbles | output | BW | Stall cycles still owed by the decode instruction |

## Verification
Two things can fall in the same cycle: both sources of one consumer can hit different producers, and those producers can sit at different ages with different class-pair gaps. The bench provokes this by issuing an FP ALU op and a load-double back to back, in both orders, to different FP registers. A consumer reading both then follows at once. The expected count is the larger of the two remaining gaps, computed by hand: 2 in one order and 3 in the other. It is checked in each stall cycle until issue, which also covers the countdown, the growing age and entry retirement in the same cycles.

// File: rtl/rgi_pkg.sv
package rgi_pkg;

    parameter int unsigned RGI_REG_W = 5;

    typedef enum logic [1:0] {
        CLS_INT    = 2'd0,
        CLS_FPALU  = 2'd1,
        CLS_LOADD  = 2'd2,
        CLS_STORED = 2'd3
    } iclass_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } dstate_e;

    typedef struct packed {
        logic                 vld;
        iclass_e              cls;
        logic                 fp;
        logic [RGI_REG_W-1:0] rn;
    } prod_t;

    function automatic logic dst_in_fp(iclass_e c);
        return c != CLS_INT;
    endfunction

    function automatic logic src_in_fp(iclass_e c, logic second);
        return (c == CLS_FPALU) || (second && c == CLS_STORED);
    endfunction

endpackage

// File: rtl/rgi_track.sv
module rgi_track
    import rgi_pkg::*;
#(
    parameter int unsigned DEPTH  = 3,
    parameter int unsigned GAP_II = 0,
    parameter int unsigned GAP_FF = 3,
    parameter int unsigned GAP_FS = 2,
    parameter int unsigned GAP_LF = 1,
    parameter int unsigned GAP_LS = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  prod_t                   push_ent,
    output prod_t [DEPTH-1:0]       slots
);

    // Largest gap a producer of this class can impose on any consumer.
    function automatic int unsigned life(iclass_e c);
        unique case (c)
            CLS_INT:    return GAP_II;
            CLS_FPALU:  return (GAP_FF > GAP_FS) ? GAP_FF : GAP_FS;
            CLS_LOADD:  return (GAP_LF > GAP_LS) ? GAP_LF : GAP_LS;
            default:    return 0;
        endcase
    endfunction

    // Slot k holds the producer issued k+1 cycles ago.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots[0] <= '0;
        end else begin
            slots[0]     <= push_ent;
            slots[0].vld <= push && (life(push_ent.cls) > 0);
        end
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[k] <= '0;
            end else begin
                slots[k]     <= slots[k-1];
                slots[k].vld <= slots[k-1].vld && (k < life(slots[k-1].cls));
            end
        end
    end

endmodule

// File: rtl/rgi_match.sv
module rgi_match
    import rgi_pkg::*;
#(
    parameter int unsigned DEPTH  = 3,
    parameter int unsigned BW     = 2,
    parameter int unsigned GAP_II = 0,
    parameter int unsigned GAP_FF = 3,
    parameter int unsigned GAP_FS = 2,
    parameter int unsigned GAP_LF = 1,
    parameter int unsigned GAP_LS = 0
) (
    input  prod_t [DEPTH-1:0]       slots,
    input  iclass_e                 cls,
    input  logic                    sa_en,
    input  logic [RGI_REG_W-1:0]    sa,
    input  logic                    sb_en,
    input  logic [RGI_REG_W-1:0]    sb,
    output logic [BW-1:0]           bubbles
);

    // Required intervening cycles for a producer/consumer class pair.
    function automatic int unsigned pair_gap(iclass_e p, iclass_e c);
        unique case (p)
            CLS_INT:   return (c == CLS_INT) ? GAP_II : 0;
            CLS_FPALU: return (c == CLS_FPALU) ? GAP_FF :
                              (c == CLS_STORED) ? GAP_FS : 0;
            CLS_LOADD: return (c == CLS_FPALU) ? GAP_LF :
                              (c == CLS_STORED) ? GAP_LS : 0;
            default:   return 0;
        endcase
    endfunction

    function automatic logic hits(prod_t e, logic en, logic fp,
                                  logic [RGI_REG_W-1:0] r);
        return e.vld && en && (e.fp == fp) && (e.rn == r) &&
               (fp || (r != '0));
    endfunction

    logic fp_a, fp_b;
    assign fp_a = src_in_fp(cls, 1'b0);
    assign fp_b = src_in_fp(cls, 1'b1);

    logic [DEPTH-1:0][BW-1:0] rem;

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_comb begin
            int unsigned need;
            need = 0;
            if (hits(slots[k], sa_en, fp_a, sa) || hits(slots[k], sb_en, fp_b, sb))
                need = pair_gap(slots[k].cls, cls);
            rem[k] = (need > k) ? BW'(need - k) : '0;
        end
    end

    always_comb begin
        bubbles = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rem[k] > bubbles) bubbles = rem[k];
        end
    end

endmodule

// File: rtl/rgi_ctrl.sv
module rgi_ctrl
    import rgi_pkg::*;
#(
    parameter int unsigned BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [BW-1:0] bubbles,
    output logic          stall,
    output logic          issue,
    output logic          hold_q
);

    dstate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    always_comb begin
        logic hazard;
        hazard = dec_valid && (bubbles != '0);
        stall  = hazard;
        issue  = dec_valid && !hazard;
        unique case (state_q)
            ST_FLOW: state_d = hazard ? ST_HOLD : ST_FLOW;  // T_DETECT
            ST_HOLD: state_d = hazard ? ST_HOLD : ST_FLOW;  // T_KEEP / T_RELEASE
            default: state_d = ST_FLOW;
        endcase
    end

    assign hold_q = (state_q == ST_HOLD);

endmodule

// File: rtl/raw_gap_interlock.sv
module raw_gap_interlock
    import rgi_pkg::*;
#(
    parameter int unsigned REG_W  = RGI_REG_W,
    parameter int unsigned GAP_II = 0,
    parameter int unsigned GAP_FF = 3,
    parameter int unsigned GAP_FS = 2,
    parameter int unsigned GAP_LF = 1,
    parameter int unsigned GAP_LS = 0,
    localparam int unsigned MAX_A = (GAP_FF > GAP_FS) ? GAP_FF : GAP_FS,
    localparam int unsigned MAX_B = (GAP_LF > GAP_LS) ? GAP_LF : GAP_LS,
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int unsigned MAX_D = (MAX_C > GAP_II) ? MAX_C : GAP_II,
    localparam int unsigned DEPTH = (MAX_D < 1) ? 1 : MAX_D,
    localparam int unsigned BW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [1:0]       dec_cls,
    input  logic             dec_dst_en,
    input  logic [REG_W-1:0] dec_dst,
    input  logic             dec_sa_en,
    input  logic [REG_W-1:0] dec_sa,
    input  logic             dec_sb_en,
    input  logic [REG_W-1:0] dec_sb,
    output logic             stall,
    output logic             issue,
    output logic [BW-1:0]    bubbles
);

    iclass_e cls;
    assign cls = iclass_e'(dec_cls);

    prod_t               push_ent;
    logic                push;
    prod_t [DEPTH-1:0]   slots;
    logic                hold_q;

    assign push_ent.vld = 1'b1;
    assign push_ent.cls = cls;
    assign push_ent.fp  = dst_in_fp(cls);
    assign push_ent.rn  = RGI_REG_W'(dec_dst);

    // Integer register zero is never a dependence source.
    assign push = issue && dec_dst_en && (cls != CLS_STORED) &&
                  (dst_in_fp(cls) || (dec_dst != '0));

    rgi_track #(
        .DEPTH(DEPTH), .GAP_II(GAP_II), .GAP_FF(GAP_FF),
        .GAP_FS(GAP_FS), .GAP_LF(GAP_LF), .GAP_LS(GAP_LS)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .push(push), .push_ent(push_ent), .slots(slots)
    );

    rgi_match #(
        .DEPTH(DEPTH), .BW(BW), .GAP_II(GAP_II), .GAP_FF(GAP_FF),
        .GAP_FS(GAP_FS), .GAP_LF(GAP_LF), .GAP_LS(GAP_LS)
    ) u_match (
        .slots(slots), .cls(cls),
        .sa_en(dec_sa_en), .sa(RGI_REG_W'(dec_sa)),
        .sb_en(dec_sb_en), .sb(RGI_REG_W'(dec_sb)),
        .bubbles(bubbles)
    );

    rgi_ctrl #(.BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .bubbles(bubbles),
        .stall(stall), .issue(issue), .hold_q(hold_q)
    );

endmodule

// File: rtl/rgi_checker.sv
module rgi_checker #(
    parameter int unsigned REG_W  = 5,
    parameter int unsigned BW     = 2,
    parameter int unsigned GAP_II = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic [1:0]       dec_cls,
    input logic             dec_sa_en,
    input logic [REG_W-1:0] dec_sa,
    input logic             dec_sb_en,
    input logic [REG_W-1:0] dec_sb,
    input logic             stall,
    input logic             issue,
    input logic [BW-1:0]    bubbles,
    input logic             hold_q
);

    assert_stall_tracks_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (stall == (bubbles != '0)));

    assert_issue_xor_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (issue != stall));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!stall && !issue));

    assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && dec_valid &&
         $stable({dec_cls, dec_sa_en, dec_sa, dec_sb_en, dec_sb}))
        |-> (bubbles == $past(bubbles) - 1'b1));

    assert_hold_follows_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> hold_q);

    assert_int_pair_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (GAP_II == 0 && dec_cls == 2'd0) |-> (bubbles == '0));

endmodule

bind raw_gap_interlock rgi_checker #(.REG_W(REG_W), .BW(BW), .GAP_II(GAP_II)) u_rgi_checker (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
    .dec_sa_en(dec_sa_en), .dec_sa(dec_sa), .dec_sb_en(dec_sb_en), .dec_sb(dec_sb),
    .stall(stall), .issue(issue), .bubbles(bubbles), .hold_q(hold_q)
);

// File: tb/test_raw_gap_interlock.sv
module test_raw_gap_interlock;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dec_valid, dec_dst_en, dec_sa_en, dec_sb_en;
    logic [1:0] dec_cls;
    logic [4:0] dec_dst, dec_sa, dec_sb;
    logic       stall, issue;
    logic [1:0] bubbles;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    raw_gap_interlock i_raw_gap_interlock (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
        .dec_dst_en(dec_dst_en), .dec_dst(dec_dst),
        .dec_sa_en(dec_sa_en), .dec_sa(dec_sa),
        .dec_sb_en(dec_sb_en), .dec_sb(dec_sb),
        .stall(stall), .issue(issue), .bubbles(bubbles)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [1:0] c, logic de, logic [4:0] d,
                         logic ae, logic [4:0] a, logic be, logic [4:0] b);
        @(negedge clk);
        dec_valid = v; dec_cls = c; dec_dst_en = de; dec_dst = d;
        dec_sa_en = ae; dec_sa = a; dec_sb_en = be; dec_sb = b;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
    endtask

    task automatic produce(logic [1:0] c, logic [4:0] d, logic de);
        drive(1'b1, c, de, d, 1'b0, 5'd0, 1'b0, 5'd0);
    endtask

    // Consumer already driven; follow it until it issues.
    task automatic follow(string req, int exp);
        for (int i = 0; i <= exp; i++) begin
            #2;
            chk(req, int'(bubbles), exp - i);
            chk(req, int'(stall), (exp - i > 0) ? 1 : 0);
            chk(req, int'(issue), (exp - i == 0) ? 1 : 0);
            if (exp - i > 0) @(negedge clk);
        end
    endtask

    function automatic int pair_gap(int p, int c);
        if (p == 1 && c == 1) return 3;   // R1
        if (p == 1 && c == 3) return 2;   // R2
        if (p == 2 && c == 1) return 1;   // R3
        return 0;                         // R4, R5, cross-file R6
    endfunction

    function automatic string tag(int p, int c, int n, bit same);
        bit pfp, cfp;
        pfp = (p != 0);
        cfp = (c != 0);
        if (!same || pfp != cfp) return "R6";
        if (pair_gap(p, c) > 0 && n >= pair_gap(p, c)) return "R9";
        if (p == 1 && c == 1) return "R1";
        if (p == 1 && c == 3) return "R2";
        if (p == 2 && c == 1) return "R3";
        if (p == 2 && c == 3) return "R4";
        return "R5";
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 2'd1, 1'b0, 5'd0, 1'b1, 5'd5, 1'b1, 5'd5);
        #2;
        chk("R11", int'(stall), 0);
        chk("R11", int'(bubbles), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R11", int'(bubbles), 0);
        chk("R11", int'(issue), 1);
        idle();

        // Sweep producer class, consumer class, spacing and register match.
        for (int p = 0; p < 3; p++) begin
            for (int ci = 0; ci < 3; ci++) begin
                for (int n = 0; n < 5; n++) begin
                    for (int s = 0; s < 2; s++) begin
                        int c, e;
                        bit pfp, cfp;
                        c = (ci == 0) ? 0 : (ci == 1) ? 1 : 3;
                        pfp = (p != 0);
                        cfp = (c != 0);
                        e = (s == 1 && pfp == cfp) ? pair_gap(p, c) - n : 0;
                        if (e < 0) e = 0;
                        repeat (4) idle();
                        produce(2'(p), 5'd5, 1'b1);
                        repeat (n) idle();
                        drive(1'b1, 2'(c), 1'b0, 5'd0, 1'b0, 5'd0,
                              1'b1, (s == 1) ? 5'd5 : 5'd6);
                        follow(tag(p, c, n, s == 1), e);
                    end
                end
            end
        end

        // R6: store base (source A) is an integer register, FP f5 does not hit it.
        repeat (4) idle();
        produce(2'd1, 5'd5, 1'b1);
        drive(1'b1, 2'd3, 1'b0, 5'd0, 1'b1, 5'd5, 1'b0, 5'd0);
        follow("R6", 0);

        // R8: FP op to f3 then load to f4, consumer reads both: max(3-1, 1-0) = 2.
        repeat (4) idle();
        produce(2'd1, 5'd3, 1'b1);
        produce(2'd2, 5'd4, 1'b1);
        drive(1'b1, 2'd1, 1'b1, 5'd7, 1'b1, 5'd3, 1'b1, 5'd4);
        follow("R8", 2);

        // R8: load to f4 then FP op to f3: max(1-1, 3-0) = 3.
        repeat (4) idle();
        produce(2'd2, 5'd4, 1'b1);
        produce(2'd1, 5'd3, 1'b1);
        drive(1'b1, 2'd1, 1'b1, 5'd7, 1'b1, 5'd4, 1'b1, 5'd3);
        follow("R8", 3);

        // R10: untracked producer (no destination write).
        repeat (4) idle();
        produce(2'd1, 5'd9, 1'b0);
        drive(1'b1, 2'd1, 1'b0, 5'd0, 1'b1, 5'd9, 1'b1, 5'd9);
        follow("R10", 0);

        // R10: matching register numbers but sources disabled.
        repeat (4) idle();
        produce(2'd1, 5'd9, 1'b1);
        drive(1'b1, 2'd1, 1'b0, 5'd0, 1'b0, 5'd9, 1'b0, 5'd9);
        follow("R10", 0);

        // R10: no instruction in decode while a hazard producer is young.
        repeat (4) idle();
        produce(2'd1, 5'd9, 1'b1);
        drive(1'b0, 2'd1, 1'b0, 5'd0, 1'b1, 5'd9, 1'b1, 5'd9);
        #2;
        chk("R10", int'(stall), 0);
        chk("R10", int'(issue), 0);

        // R7: a stalled consumer issues exactly after the full gap.
        repeat (4) idle();
        produce(2'd1, 5'd2, 1'b1);
        drive(1'b1, 2'd3, 1'b0, 5'd0, 1'b1, 5'd1, 1'b1, 5'd2);
        follow("R7", 2);
        idle();
        #2;
        chk("R7", int'(stall), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule